// File: doc/BRIEF.md
# Link Receive Packet Deframer

This block sits behind the capture stage of a source-synchronous chip-to-chip link. Each core clock it is handed one already-captured byte and the level of the framing line. From this stream it rebuilds parallel transactions. Each transaction carries a header made of a control mode, a 32-bit destination address, a data mode, a write flag and an access flag. A read carries a 32-bit return address and a write carries up to 64 bits of data. Each transaction is presented for one cycle.

A packet opens on a rising edge of the framing line. If the framing line stays high after the last data byte, the link is bursting. The next byte is then taken as the first data byte of a further transaction. That transaction reuses the previous header and its destination address is advanced by eight. A framing line that drops in the middle of a packet throws the partial packet away and latches an error flag. The block also returns write-wait and read-wait levels toward the far end. These are registered copies of the local write-full and read-full inputs.

The controller walks five named states:
- IDLE watches for the rising edge (IDLE→HDR).
- HDR takes header bytes 1 to 5 (HDR→LO after byte 5, HDR→IDLE on a drop).
- LO takes data bytes 6 to 9 (LO→HI after byte 9, LO→IDLE on a drop).
- HI takes bytes 10 to 13. HI→IDLE happens with a narrow emit when framing is low at slot 10, and with a drop when it is low at slots 11 to 13. HI→CONT happens with a wide emit after byte 13.
- CONT decides between a burst continuation (CONT→LO) and the end of the packet (CONT→IDLE).

Top module: `lrx_deframer`

## Requirements
- R1: A byte sampled with `rx_frame` high, where `rx_frame` was low at the previous sample, is byte 0 of a new packet. Its contents are ignored.
- R2: Byte 1 bits [7:4] give the control mode and bits [3:0] give destination address bits [31:28]. Bytes 2, 3 and 4 give address bits [27:20], [19:12] and [11:4]. Byte 5 gives address bits [3:0] in [7:4], the data mode in [3:2], the write flag in [1] and the access flag in [0].
- R3: Bytes 6 to 9 form a 32-bit word, most significant byte first. If the write flag is 1, the word appears on `txn_data[31:0]` and `txn_src` is zero. If the write flag is 0, the word appears on `txn_src` and `txn_data[31:0]` is zero.
- R4: Bytes 10 to 13 form `txn_data[63:32]`, most significant byte first. `txn_valid` is high in the cycle after the clock edge that samples byte 13.
- R5: If `rx_frame` is low at the byte position following byte 9, the transaction ends narrow. `txn_valid` is high in the cycle after that edge, with `txn_data[63:32]` zero.
- R6: If `rx_frame` is high at the byte after byte 13, that byte is data byte 6 of a burst transaction. The burst transaction keeps the previous header and has destination address = previous address + 8, modulo 2^32.
- R7: `rx_frame` low at any position from byte 1 to byte 9 or from byte 11 to byte 13 discards the partial packet, emits no transaction and sets `frame_err`.
- R8: `frame_err` stays high until reset once set.
- R9: `wr_wait` and `rd_wait` equal `wr_full` and `rd_full` as sampled at the previous clock edge.
- R10: During and right after reset, `txn_valid`, `frame_err`, `wr_wait` and `rd_wait` are 0. `txn_valid` is never high on two consecutive cycles.
- R11: After a discarded or completed packet, the next rising edge of `rx_frame` starts a packet that is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_frame | input | 1 | Framing level captured with the byte |
| rx_byte | input | 8 | Captured link byte |
| wr_full | input | 1 | Local write path cannot accept more |
| rd_full | input | 1 | Local read path cannot accept more |
| txn_valid | output | 1 | One-cycle strobe for a rebuilt transaction |
| txn_access | output | 1 | Access flag from the header |
| txn_write | output | 1 | Write flag from the header |
| txn_datamode | output | 2 | Data size code from the header |
| txn_ctrlmode | output | 4 | Control mode from the header |
| txn_dst | output | 32 | Destination address |
| txn_src | output | 32 | Return address of a read |
| txn_data | output | 64 | Write data |
| frame_err | output | 1 | Sticky framing error flag |
| wr_wait | output | 1 | Write push-back toward the far end |
| rd_wait | output | 1 | Read push-back toward the far end |

## Verification
The emission of a finished wide transaction and the capture of the next burst byte fall in the same cycle. In that cycle the output registers take the old header while the working address advances by eight. Back-to-back bursts provoke this, including one that wraps the address through zero. Each emitted transaction is compared field by field with a value the bench builds from the fields it sent. The wait copies change in the same cycles as the packet traffic, since their inputs are randomized every cycle. They are compared every cycle against the level sampled one edge earlier.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    localparam int LRX_BW   = 8;
    localparam int LRX_AW   = 32;
    localparam int LRX_DW   = 64;
    localparam int LRX_WW   = LRX_DW / 2;
    localparam int LRX_CMW  = 4;
    localparam int LRX_DMW  = 2;
    localparam int SLOT_W   = 4;

    // byte positions inside a packet
    localparam logic [SLOT_W-1:0] SL_HDR_FIRST = 4'd1;
    localparam logic [SLOT_W-1:0] SL_HDR_LAST  = 4'd5;
    localparam logic [SLOT_W-1:0] SL_LO_FIRST  = 4'd6;
    localparam logic [SLOT_W-1:0] SL_LO_LAST   = 4'd9;
    localparam logic [SLOT_W-1:0] SL_HI_FIRST  = 4'd10;
    localparam logic [SLOT_W-1:0] SL_HI_LAST   = 4'd13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_LO,
        ST_HI,
        ST_CONT
    } lrx_state_t;

    typedef struct packed {
        logic [LRX_CMW-1:0] ctrlmode;
        logic [LRX_AW-1:0]  dst;
        logic [LRX_DMW-1:0] datamode;
        logic               write;
        logic               access;
    } lrx_hdr_t;

endpackage

// File: rtl/lrx_ctrl.sv
module lrx_ctrl
    import lrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_frame,
    output logic              cap,
    output logic [SLOT_W-1:0] slot_o,
    output logic              burst,
    output logic              emit,
    output logic              wide,
    output logic              drop
);

    lrx_state_t        state, nxt;
    logic [SLOT_W-1:0] slot, nslot;
    logic              prev_frame;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            slot       <= '0;
            prev_frame <= 1'b1;
        end else begin
            state      <= nxt;
            slot       <= nslot;
            prev_frame <= rx_frame;
        end
    end

    // transitions and per-byte controls
    always_comb begin
        nxt   = state;
        nslot = slot;
        cap   = 1'b0;
        burst = 1'b0;
        emit  = 1'b0;
        wide  = 1'b0;
        drop  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rx_frame && !prev_frame) begin
                    nxt   = ST_HDR;
                    nslot = SL_HDR_FIRST;
                end
            end
            ST_HDR: begin
                if (rx_frame) begin
                    cap = 1'b1;
                    if (slot == SL_HDR_LAST) begin
                        nxt   = ST_LO;
                        nslot = SL_LO_FIRST;
                    end else begin
                        nslot = slot + 4'd1;
                    end
                end else begin
                    drop = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            ST_LO: begin
                if (rx_frame) begin
                    cap = 1'b1;
                    if (slot == SL_LO_LAST) begin
                        nxt   = ST_HI;
                        nslot = SL_HI_FIRST;
                    end else begin
                        nslot = slot + 4'd1;
                    end
                end else begin
                    drop = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            ST_HI: begin
                if (rx_frame) begin
                    cap = 1'b1;
                    if (slot == SL_HI_LAST) begin
                        emit  = 1'b1;
                        wide  = 1'b1;
                        nxt   = ST_CONT;
                        nslot = SL_LO_FIRST;
                    end else begin
                        nslot = slot + 4'd1;
                    end
                end else if (slot == SL_HI_FIRST) begin
                    emit = 1'b1;
                    nxt  = ST_IDLE;
                end else begin
                    drop = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
            ST_CONT: begin
                if (rx_frame) begin
                    cap   = 1'b1;
                    burst = 1'b1;
                    nxt   = ST_LO;
                    nslot = SL_LO_FIRST + 4'd1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
        endcase
    end

    assign slot_o = slot;

endmodule

// File: rtl/lrx_asm.sv
module lrx_asm
    import lrx_pkg::*;
#(
    parameter int BURST_STEP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LRX_BW-1:0]  rx_byte,
    input  logic               cap,
    input  logic [SLOT_W-1:0]  slot,
    input  logic               burst,
    input  logic               emit,
    input  logic               wide,
    input  logic               drop,
    output logic               txn_valid,
    output lrx_hdr_t           txn_hdr,
    output logic [LRX_AW-1:0]  txn_src,
    output logic [LRX_DW-1:0]  txn_data,
    output logic               frame_err
);

    lrx_hdr_t          hdr;
    logic [LRX_WW-1:0] lo_w, hi_w, hi_next;

    assign hi_next = wide ? {hi_w[LRX_WW-LRX_BW-1:0], rx_byte} : '0;

    // working header and data words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr  <= '0;
            lo_w <= '0;
            hi_w <= '0;
        end else if (cap) begin
            if (slot == SL_HDR_FIRST) begin
                hdr.ctrlmode  <= rx_byte[7:4];
                hdr.dst[31:28] <= rx_byte[3:0];
            end else if (slot == SL_HDR_FIRST + 4'd1) begin
                hdr.dst[27:20] <= rx_byte;
            end else if (slot == SL_HDR_FIRST + 4'd2) begin
                hdr.dst[19:12] <= rx_byte;
            end else if (slot == SL_HDR_FIRST + 4'd3) begin
                hdr.dst[11:4] <= rx_byte;
            end else if (slot == SL_HDR_LAST) begin
                hdr.dst[3:0]  <= rx_byte[7:4];
                hdr.datamode  <= rx_byte[3:2];
                hdr.write     <= rx_byte[1];
                hdr.access    <= rx_byte[0];
            end else if (slot <= SL_LO_LAST) begin
                lo_w <= {lo_w[LRX_WW-LRX_BW-1:0], rx_byte};
                if (burst) begin
                    hdr.dst <= hdr.dst + LRX_AW'(BURST_STEP);
                end
            end else begin
                hi_w <= {hi_w[LRX_WW-LRX_BW-1:0], rx_byte};
            end
        end
    end

    // presented transaction and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_valid <= 1'b0;
            txn_hdr   <= '0;
            txn_src   <= '0;
            txn_data  <= '0;
            frame_err <= 1'b0;
        end else begin
            txn_valid <= emit;
            frame_err <= frame_err | drop;
            if (emit) begin
                txn_hdr  <= hdr;
                txn_src  <= hdr.write ? '0 : lo_w;
                txn_data <= {hi_next, (hdr.write ? lo_w : {LRX_WW{1'b0}})};
            end
        end
    end

endmodule

// File: rtl/lrx_wait.sv
module lrx_wait #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] full,
    output logic [NCH-1:0] wait_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) wait_o[c] <= 1'b0;
            else        wait_o[c] <= full[c];
        end
    end

endmodule

// File: rtl/lrx_deframer.sv
module lrx_deframer
    import lrx_pkg::*;
#(
    parameter int BURST_STEP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_frame,
    input  logic [LRX_BW-1:0]  rx_byte,
    input  logic               wr_full,
    input  logic               rd_full,
    output logic               txn_valid,
    output logic               txn_access,
    output logic               txn_write,
    output logic [LRX_DMW-1:0] txn_datamode,
    output logic [LRX_CMW-1:0] txn_ctrlmode,
    output logic [LRX_AW-1:0]  txn_dst,
    output logic [LRX_AW-1:0]  txn_src,
    output logic [LRX_DW-1:0]  txn_data,
    output logic               frame_err,
    output logic               wr_wait,
    output logic               rd_wait
);

    localparam int NCH = 2;

    logic              cap, burst, emit, wide, drop;
    logic [SLOT_W-1:0] slot;
    lrx_hdr_t          hdr_o;
    logic [NCH-1:0]    waits;

    lrx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_frame(rx_frame),
        .cap     (cap),
        .slot_o  (slot),
        .burst   (burst),
        .emit    (emit),
        .wide    (wide),
        .drop    (drop)
    );

    lrx_asm #(.BURST_STEP(BURST_STEP)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .cap      (cap),
        .slot     (slot),
        .burst    (burst),
        .emit     (emit),
        .wide     (wide),
        .drop     (drop),
        .txn_valid(txn_valid),
        .txn_hdr  (hdr_o),
        .txn_src  (txn_src),
        .txn_data (txn_data),
        .frame_err(frame_err)
    );

    lrx_wait #(.NCH(NCH)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .full  ({rd_full, wr_full}),
        .wait_o(waits)
    );

    assign txn_access   = hdr_o.access;
    assign txn_write    = hdr_o.write;
    assign txn_datamode = hdr_o.datamode;
    assign txn_ctrlmode = hdr_o.ctrlmode;
    assign txn_dst      = hdr_o.dst;
    assign wr_wait      = waits[0];
    assign rd_wait      = waits[1];

endmodule

// File: rtl/lrx_chk.sv
module lrx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_frame,
    input logic wr_full,
    input logic rd_full,
    input logic txn_valid,
    input logic frame_err,
    input logic wr_wait,
    input logic rd_wait
);

    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_err_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> !$past(rx_frame));

    p_wr_wait_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_wait == $past(wr_full)));

    p_rd_wait_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_wait == $past(rd_full)));

endmodule

bind lrx_deframer lrx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_frame (rx_frame),
    .wr_full  (wr_full),
    .rd_full  (rd_full),
    .txn_valid(txn_valid),
    .frame_err(frame_err),
    .wr_wait  (wr_wait),
    .rd_wait  (rd_wait)
);

// File: tb/sim_lrx_deframer.sv
`timescale 1ns/1ps
module sim_lrx_deframer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_frame;
    logic [7:0]  rx_byte;
    logic        wr_full, rd_full;
    logic        txn_valid, txn_access, txn_write;
    logic [1:0]  txn_datamode;
    logic [3:0]  txn_ctrlmode;
    logic [31:0] txn_dst, txn_src;
    logic [63:0] txn_data;
    logic        frame_err, wr_wait, rd_wait;

    int errors = 0;
    int checks = 0;
    logic started = 1'b0;
    logic done = 1'b0;
    logic wf_q = 1'b0, rf_q = 1'b0;
    logic [135:0] expq[$];

    always #2 clk = ~clk;

    lrx_deframer u0 (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [135:0] build_exp(input logic acc, input logic wr, input logic [1:0] dm,
        input logic [3:0] cm, input logic [31:0] dst, input logic [31:0] lo, input logic [31:0] hi,
        input logic wide);
        logic [31:0] src, dlo, dhi;
        src = wr ? 32'h0 : lo;
        dlo = wr ? lo : 32'h0;
        dhi = wide ? hi : 32'h0;
        return {acc, wr, dm, cm, dst, src, dhi, dlo};
    endfunction

    task automatic put_byte(input logic f, input logic [7:0] b);
        @(negedge clk);
        rx_frame = f;
        rx_byte  = b;
    endtask

    task automatic put_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) put_byte(1'b1, w[i*8 +: 8]);
    endtask

    // R1 R2 R3 R4 R5 R6: one packet, optional burst continuations, then a gap
    task automatic send_packet(input logic [3:0] cm, input logic [31:0] dst, input logic [1:0] dm,
        input logic wr, input logic acc, input logic wide, input int nb, input int gap);
        logic [31:0] r, lo, hi, d;
        d  = dst;
        r  = $urandom;
        lo = $urandom;
        hi = $urandom;
        expq.push_back(build_exp(acc, wr, dm, cm, d, lo, hi, wide));
        put_byte(1'b1, r[7:0]);
        put_byte(1'b1, {cm, d[31:28]});
        put_byte(1'b1, d[27:20]);
        put_byte(1'b1, d[19:12]);
        put_byte(1'b1, d[11:4]);
        put_byte(1'b1, {d[3:0], dm, wr, acc});
        put_word(lo);
        if (wide) begin
            put_word(hi);
            for (int k = 0; k < nb; k++) begin
                d  = d + 32'd8;
                lo = $urandom;
                hi = $urandom;
                expq.push_back(build_exp(acc, wr, dm, cm, d, lo, hi, 1'b1));
                put_word(lo);
                put_word(hi);
            end
        end
        for (int g = 0; g < gap; g++) begin
            r = $urandom;
            put_byte(1'b0, r[7:0]);
        end
    endtask

    // R7: nhigh bytes with frame high (byte 0 included), then frame low
    task automatic send_trunc(input int nhigh);
        logic [31:0] r;
        for (int i = 0; i < nhigh; i++) begin
            r = $urandom;
            put_byte(1'b1, r[7:0]);
        end
        put_byte(1'b0, 8'h00);
        put_byte(1'b0, 8'h00);
    endtask

    // transaction monitor
    always @(negedge clk) begin
        if (rst_n && txn_valid) begin
            logic [135:0] act, e;
            act = {txn_access, txn_write, txn_datamode, txn_ctrlmode, txn_dst, txn_src, txn_data};
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected transaction act=%h exp=none", act);
            end else begin
                e = expq.pop_front();
                if (act !== e) begin
                    errors++;
                    $display("FAIL R2/R3/R4/R5/R6 transaction act=%h exp=%h", act, e);
                end
            end
        end
    end

    // wait copies (R9)
    always @(posedge clk) begin
        wf_q <= wr_full;
        rf_q <= rd_full;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(wr_wait === wf_q, "R9 wr_wait", {63'd0, wr_wait}, {63'd0, wf_q});
            chk(rd_wait === rf_q, "R9 rd_wait", {63'd0, rd_wait}, {63'd0, rf_q});
        end
    end

    initial begin
        logic [31:0] t;
        wait (started);
        while (!done) begin
            @(negedge clk);
            t = $urandom;
            wr_full = t[0];
            rd_full = t[1];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r1, r2, r3;
        void'($urandom(32'd4242));
        rst_n = 1'b0; rx_frame = 1'b0; rx_byte = 8'h00; wr_full = 1'b0; rd_full = 1'b0;
        repeat (3) @(negedge clk);
        chk(txn_valid === 1'b0, "R10 reset valid", {63'd0, txn_valid}, 64'd0);
        chk(frame_err === 1'b0, "R10 reset err", {63'd0, frame_err}, 64'd0);
        chk({wr_wait, rd_wait} === 2'b00, "R10 reset waits", {62'd0, wr_wait, rd_wait}, 64'd0);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);

        // directed: narrow read (R3 R5)
        send_packet(4'h5, 32'h8100_0040, 2'd2, 1'b0, 1'b1, 1'b0, 0, 1);
        // directed: wide write bursting through address wrap (R4 R6)
        send_packet(4'hA, 32'hFFFF_FFF0, 2'd3, 1'b1, 1'b1, 1'b1, 2, 2);
        // directed: one-byte gap then next packet (R11)
        send_packet(4'h0, 32'h0000_1230, 2'd1, 1'b1, 1'b0, 1'b0, 0, 1);
        send_packet(4'hF, 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b1, 0, 1);

        // constrained random
        for (int n = 0; n < 40; n++) begin
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            send_packet(r1[3:0], r2, r1[5:4], r1[6], r1[7], r1[8], r1[8] ? int'(r3[1:0]) : 0,
                        1 + int'(r3[3:2]));
        end
        repeat (3) @(negedge clk);
        chk(frame_err === 1'b0, "R7 no error on clean traffic", {63'd0, frame_err}, 64'd0);
        chk(expq.size() == 0, "R4/R5 all transactions seen", 64'(expq.size()), 64'd0);

        // truncation in header (R7)
        send_trunc(3);
        @(negedge clk);
        chk(frame_err === 1'b1, "R7 drop in header sets error", {63'd0, frame_err}, 64'd1);
        // truncation at byte 9 and at byte 12 (R7)
        send_trunc(9);
        send_trunc(12);
        @(negedge clk);
        chk(expq.size() == 0, "R7 no transaction from dropped packets", 64'(expq.size()), 64'd0);

        // recovery (R11) and stickiness (R8)
        send_packet(4'h3, 32'hDEAD_BEE8, 2'd2, 1'b1, 1'b1, 1'b1, 1, 2);
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R11 packet after drop decoded", 64'(expq.size()), 64'd0);
        chk(frame_err === 1'b1, "R8 error stays set", {63'd0, frame_err}, 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule